// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the message-passing interrupts between the two ports of a shared memory. The two highest addresses of the address space are reserved as mailboxes. The all-ones address belongs to the right port, and the address one below it belongs to the left port. When one port writes a message into the other port's mailbox, the owner of that mailbox receives an active-low interrupt. The interrupt stays asserted until the owner reads its own mailbox.

Each port has a busy input that comes from the contention arbiter. A port whose busy input is high cannot raise the interrupt of the opposite port. It also cannot clear its own interrupt by reading. Each mailbox is a single data register that holds the last message written to it. The block does not interpret the message contents. Reads of the mailboxes are combinational, and every other address reads as zero at this block's data outputs.

Top module: `mbox_irq`

## Requirements
- R1: After reset both `l_irq_n` and `r_irq_n` are 1 (inactive), and both mailbox registers hold zero.
- R2: The right mailbox is the address with all ADDR_W bits set to 1. The left mailbox is that address with bit 0 cleared. Any other address has no effect on interrupts or mailbox contents and reads as zero on `*_rdata`.
- R3: A left-port write (`l_en`=1, `l_we`=1) to the right mailbox while `l_busy`=0 drives `r_irq_n` to 0 from the next clock edge.
- R4: A right-port write to the left mailbox while `r_busy`=0 drives `l_irq_n` to 0 from the next clock edge.
- R5: An owner read (`*_en`=1, `*_we`=0) of its own mailbox while its busy is 0 returns its interrupt output to 1 at the next clock edge.
- R6: A read by a port of the other port's mailbox changes neither interrupt.
- R7: A cross-port mailbox write made while the writer's busy is 1 leaves the owner's interrupt unchanged. The data is still stored.
- R8: An owner read of its own mailbox made while its busy is 1 leaves its interrupt unchanged.
- R9: When a set (R3/R4) and a clear (R5) reach the same interrupt in one cycle, the interrupt is asserted (0) after the edge.
- R10: A port writing its own mailbox stores the data but changes neither interrupt.
- R11: `*_rdata` shows the addressed mailbox's content combinationally. When both ports write the same mailbox in one cycle, the non-owner's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port access strobe |
| l_we | input | 1 | Left port write (1) / read (0) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_busy | input | 1 | Left port busy from arbiter |
| l_rdata | output | DATA_W | Left port mailbox read data |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_en | input | 1 | Right port access strobe |
| r_we | input | 1 | Right port write (1) / read (0) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_busy | input | 1 | Right port busy from arbiter |
| r_rdata | output | DATA_W | Right port mailbox read data |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=16. With only sixteen addresses, random stimulus lands on the two mailbox addresses often. As a result, cross-port writes, owner reads, busy vetoes and same-cycle set/clear collisions all occur many times in a short run. The 16-bit data width lets the test tell the two ports' messages apart when both write the same mailbox in one cycle.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] l_box_q, r_box_q;
  logic              l_flag_q, r_flag_q;

  wire l_hit_l = (l_addr == L_BOX);
  wire l_hit_r = (l_addr == R_BOX);
  wire r_hit_l = (r_addr == L_BOX);
  wire r_hit_r = (r_addr == R_BOX);

  wire l_wr = l_en & l_we;
  wire l_rd = l_en & ~l_we;
  wire r_wr = r_en & r_we;
  wire r_rd = r_en & ~r_we;

  wire set_l = r_wr & r_hit_l & ~r_busy;
  wire clr_l = l_rd & l_hit_l & ~l_busy;
  wire set_r = l_wr & l_hit_r & ~l_busy;
  wire clr_r = r_rd & r_hit_r & ~r_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_flag_q <= 1'b0;
      r_flag_q <= 1'b0;
    end else begin
      if (set_l)      l_flag_q <= 1'b1;
      else if (clr_l) l_flag_q <= 1'b0;
      if (set_r)      r_flag_q <= 1'b1;
      else if (clr_r) r_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_box_q <= '0;
      r_box_q <= '0;
    end else begin
      if (r_wr && r_hit_l)      l_box_q <= r_wdata;
      else if (l_wr && l_hit_l) l_box_q <= l_wdata;
      if (l_wr && l_hit_r)      r_box_q <= l_wdata;
      else if (r_wr && r_hit_r) r_box_q <= r_wdata;
    end
  end

  assign l_irq_n = ~l_flag_q;
  assign r_irq_n = ~r_flag_q;

  assign l_rdata = l_hit_r ? r_box_q : (l_hit_l ? l_box_q : '0);
  assign r_rdata = r_hit_r ? r_box_q : (r_hit_l ? l_box_q : '0);

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (l_irq_n && r_irq_n)); // R1
  AST_SET_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && l_addr == R_BOX && !l_busy) |=> !r_irq_n); // R3
  AST_SET_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_we && r_addr == L_BOX && !r_busy) |=> !l_irq_n); // R4
  AST_CLR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_we && l_addr == L_BOX && !l_busy && !(r_en && r_we && r_addr == L_BOX && !r_busy)) |=> l_irq_n); // R5
  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && r_we && r_addr == L_BOX && !r_busy) && !(l_en && !l_we && l_addr == L_BOX && !l_busy)
    |=> $stable(l_irq_n)); // R8
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && l_we && l_addr == R_BOX && !l_busy) && !(r_en && !r_we && r_addr == R_BOX && !r_busy)
    |=> $stable(r_irq_n)); // R7

endmodule

// File: tb/sim_mbox_irq.sv
module sim_mbox_irq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic l_en = 0, l_we = 0, l_busy = 0, r_en = 0, r_we = 0, r_busy = 0;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_wdata = 0, r_wdata = 0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic m_lf = 0, m_rf = 0;
  logic [DW-1:0] m_lbox = 0, m_rbox = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_busy(l_busy),
    .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_busy(r_busy),
    .r_rdata(r_rdata), .r_irq_n(r_irq_n));

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    if (a == 4'hF) return m_rbox;
    if (a == 4'hE) return m_lbox;
    return '0;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic le, lw, input logic [AW-1:0] la, input logic [DW-1:0] ld, input logic lb,
                      input logic re, rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd, input logic rb,
                      input string req);
    logic nlf, nrf;
    l_en = le; l_we = lw; l_addr = la; l_wdata = ld; l_busy = lb;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rd; r_busy = rb;
    #1;
    check({req, " R11 l_rdata"}, l_rdata, exp_rd(la));
    check({req, " R11 r_rdata"}, r_rdata, exp_rd(ra));
    nlf = m_lf; nrf = m_rf;
    if (le && !lw && la == 4'hE && !lb) nlf = 0;
    if (re && rw && ra == 4'hE && !rb) nlf = 1;
    if (re && !rw && ra == 4'hF && !rb) nrf = 0;
    if (le && lw && la == 4'hF && !lb) nrf = 1;
    @(posedge clk);
    m_lf = nlf; m_rf = nrf;
    if (re && rw && ra == 4'hE) m_lbox = rd; else if (le && lw && la == 4'hE) m_lbox = ld;
    if (le && lw && la == 4'hF) m_rbox = ld; else if (re && rw && ra == 4'hF) m_rbox = rd;
    @(negedge clk);
    check({req, " l_irq_n"}, {15'd0, l_irq_n}, {15'd0, ~m_lf});
    check({req, " r_irq_n"}, {15'd0, r_irq_n}, {15'd0, ~m_rf});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 l_irq_n reset", {15'd0, l_irq_n}, 16'd1);
    check("R1 r_irq_n reset", {15'd0, r_irq_n}, 16'd1);
    step(0,0,4'hF,0,0, 0,0,4'hE,0,0, "R1 R2 boxes zero");
    step(1,1,4'hE,16'h1111,0, 0,0,0,0,0, "R10 own write left");
    step(0,0,0,0,0, 1,1,4'hD,16'hDEAD,0, "R2 other addr");
    step(0,0,4'hD,0,0, 0,0,4'hD,0,0, "R2 other addr reads zero");
    step(0,0,0,0,0, 1,1,4'hE,16'h2222,0, "R4 right sets left");
    step(1,0,4'hF,0,0, 1,0,4'hE,0,0, "R6 cross reads");
    step(1,0,4'hE,0,1, 0,0,0,0,0, "R8 busy read");
    step(1,0,4'hE,0,0, 0,0,0,0,0, "R5 owner read");
    step(1,1,4'hF,16'h3333,1, 0,0,0,0,0, "R7 busy write");
    step(1,1,4'hF,16'h4444,0, 0,0,0,0,0, "R3 left sets right");
    step(0,0,0,0,0, 1,0,4'hF,0,0, "R5 right read");
    step(1,1,4'hF,16'h5555,0, 1,0,4'hF,0,0, "R9 set beats clear");
    step(1,1,4'hE,16'h6666,0, 1,1,4'hE,16'h7777,0, "R11 both write");
    step(0,0,0,0,0, 1,1,4'hF,16'h8888,0, "R10 own write right");
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] la, ra;
      la = ($urandom % 2) ? 4'hE + AW'($urandom % 2) : AW'($urandom);
      ra = ($urandom % 2) ? 4'hE + AW'($urandom % 2) : AW'($urandom);
      step($urandom%4 != 0, $urandom%2 == 0, la, DW'($urandom), $urandom%4 == 0,
           $urandom%4 != 0, $urandom%2 == 0, ra, DW'($urandom), $urandom%4 == 0,
           "random R3/R4/R5/R7/R8/R9");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule